// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control path a small CPU core uses to move from an accepted interrupt to the first fetch of its handler. A hardware request is taken only when the current instruction retires, or at once when a suspendable long string instruction is running. A software interrupt instruction is taken when it retires. The sequencer then runs a fixed multi-cycle sequence on a simple byte memory port. For a hardware request, an information read returns the interrupt number and request level. The sequencer then updates the flags, pushes the old flags and the PC onto the stack, loads the priority level and reads the handler address from the vector table.

The pre-entry flags are held in a private copy for the whole sequence. The stack frame is written in an interleaved address order. The stack-select flag survives only for software interrupts numbered 32 to 63, so those handlers may keep running on the user stack. Arbitration among sources, the return path and decoding are handled elsewhere. The core applies the `flg_we_o`, `pc_we_o` and `sp_we_o` updates.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware request (`irq_pend_i`) is accepted only in an idle cycle where `insn_done_i` is high; it is ignored otherwise. The cycle after acceptance is the information slot.
- R2: A hardware request is also accepted in an idle cycle where `str_susp_i` is high, with the same timing as R1.
- R3: In the information slot with `queue_ok_i` high, `rd_o` and `irq_ack_o` are high and `addr_o` is 0. `rdata_i[5:0]` gives the interrupt number and `rdata_i[10:8]` gives the request level.
- R4: While `queue_ok_i` is low in the information slot, `rd_o` and `irq_ack_o` stay low and the slot repeats as a wait state.
- R5: In the cycle after the information read, `flg_we_o` pulses. `flg_o` then equals the pre-entry flags with bit 6 (interrupt enable), bit 1 (single step) and bit 7 (stack select) cleared.
- R6: A software request (`sw_req_i` with `insn_done_i`, and no hardware request) skips the information slot. The next cycle is the flag update. The number comes from `sw_num_i`, the level is the current flags `[14:12]`, and bit 7 keeps its old value when the number is 32 to 63.
- R7: The following four cycles each make one byte write (`wr_o`), at SP-2, SP-1, SP-4 and SP-3 in that order. The data are flags[7:0], {flags[15:12], PC[19:16]}, PC[7:0] and PC[15:8]. SP is `usp_i` when the updated bit 7 is 1, and `isp_i` otherwise.
- R8: The next cycle pulses `flg_we_o` again. `flg_o` equals the R5/R6 value with bits [14:12] set to the accepted level.
- R9: The next three cycles read bytes at VEC, VEC+1 and VEC+2, where VEC = base + 4·number. The base is 0xFFF00 for numbers below 32 and `vbase_i` otherwise.
- R10: The next cycle pulses `done_o`, `pc_we_o` and `sp_we_o` for one cycle. `pc_o` = {byte2[3:0], byte1, byte0}, `sp_o` = SP-4 and `sp_u_o` = updated bit 7. The block is then idle.
- R11: If a hardware request and a software request qualify in the same cycle, the hardware request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_done_i | input | 1 | Current instruction retires this cycle |
| str_susp_i | input | 1 | Suspendable string instruction in progress |
| irq_pend_i | input | 1 | Hardware interrupt pending |
| sw_req_i | input | 1 | Retiring instruction is a software interrupt |
| sw_num_i | input | 6 | Software interrupt number |
| queue_ok_i | input | 1 | Instruction queue can accept the information read |
| flg_i | input | 16 | Current flag register |
| pc_i | input | 20 | Return PC |
| isp_i | input | 20 | Interrupt stack pointer |
| usp_i | input | 20 | User stack pointer |
| vbase_i | input | 20 | Relocatable vector table base |
| addr_o | output | 20 | Memory address |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| wdata_o | output | 8 | Write data byte |
| rdata_i | input | 16 | Read data (info word or byte in [7:0]) |
| irq_ack_o | output | 1 | Clears the accepted source's request bit |
| flg_o | output | 16 | New flag value |
| flg_we_o | output | 1 | Flag write enable |
| pc_o | output | 20 | Handler address |
| pc_we_o | output | 1 | PC write enable |
| sp_o | output | 20 | New stack pointer value |
| sp_we_o | output | 1 | Stack pointer write enable |
| sp_u_o | output | 1 | 1: write user stack pointer, 0: interrupt stack pointer |
| done_o | output | 1 | Sequence complete, fetch may resume |

## Verification
Every hardware interrupt number from 0 to 63 is entered once. The entries alternate between the retire trigger and the string-suspend trigger, and use 0 to 2 queue wait slots, so both halves of the vector base select are covered along with the wait-state path. Every software number from 0 to 63 is also entered, with the stack-select flag set in half the runs. This separates the numbers whose flag is preserved from those whose flag is cleared, and it shows that the frame then goes to the user stack. Memory returns address-dependent bytes, so a wrong vector address, a swapped push slot or a misassembled handler address shows up as a data mismatch. Simultaneous hardware and software triggers, and triggers without a qualifying boundary, test R11 and the rejection part of R1.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  parameter int ADDR_W = 20;
  parameter int NUM_W  = 6;
  parameter int LVL_W  = 3;
  parameter int FLG_W  = 16;
  parameter int BYTE_W = 8;
  parameter int RD_W   = 16;

  parameter int FLG_DBG = 1;
  parameter int FLG_IEN = 6;
  parameter int FLG_USP = 7;
  parameter int IPL_LSB = 12;
  parameter int INFO_LVL_LSB = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INFO, ST_SAVE,
    ST_PUSH0, ST_PUSH1, ST_PUSH2, ST_PUSH3,
    ST_IPL, ST_VEC0, ST_VEC1, ST_VEC2, ST_LOAD
  } st_e;
endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic insn_done_i,
  input  logic str_susp_i,
  input  logic irq_pend_i,
  input  logic sw_req_i,
  input  logic queue_ok_i,
  output st_e  st_o,
  output logic accept_o,
  output logic hw_sel_o
);
  st_e  st_q, st_d;
  logic hw_go, sw_go;

  assign hw_go    = irq_pend_i && (insn_done_i || str_susp_i);
  assign sw_go    = sw_req_i && insn_done_i;
  assign accept_o = (st_q == ST_IDLE) && (hw_go || sw_go);
  assign hw_sel_o = hw_go;
  assign st_o     = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept_o) st_d = hw_go ? ST_INFO : ST_SAVE;
      ST_INFO:  if (queue_ok_i) st_d = ST_SAVE;
      ST_SAVE:  st_d = ST_PUSH0;
      ST_PUSH0: st_d = ST_PUSH1;
      ST_PUSH1: st_d = ST_PUSH2;
      ST_PUSH2: st_d = ST_PUSH3;
      ST_PUSH3: st_d = ST_IPL;
      ST_IPL:   st_d = ST_VEC0;
      ST_VEC0:  st_d = ST_VEC1;
      ST_VEC1:  st_d = ST_VEC2;
      ST_VEC2:  st_d = ST_LOAD;
      ST_LOAD:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assert_hw_enters_info_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && irq_pend_i && (insn_done_i || str_susp_i)) |=> (st_q == ST_INFO));
  assert_sw_skips_info_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !irq_pend_i && sw_req_i && insn_done_i) |=> (st_q == ST_SAVE));
  assert_info_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INFO && !queue_ok_i) |=> (st_q == ST_INFO));
endmodule

// File: rtl/irq_entry_flags.sv
module irq_entry_flags
  import irq_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               st_i,
  input  logic              accept_i,
  input  logic              hw_sel_i,
  input  logic              queue_ok_i,
  input  logic [NUM_W-1:0]  sw_num_i,
  input  logic [FLG_W-1:0]  flg_i,
  input  logic [RD_W-1:0]   rdata_i,
  output logic [FLG_W-1:0]  flg_o,
  output logic              flg_we_o,
  output logic [FLG_W-1:0]  tmp_o,
  output logic [NUM_W-1:0]  num_o,
  output logic              u_sel_o
);
  logic [FLG_W-1:0] tmp_q, flg_save, flg_ipl;
  logic [NUM_W-1:0] num_q;
  logic [LVL_W-1:0] lvl_q;
  logic             sw_q, keep_u;
  logic             unused_rd;

  assign unused_rd = ^{rdata_i[RD_W-1:INFO_LVL_LSB+LVL_W], rdata_i[INFO_LVL_LSB-1:NUM_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q <= '0;
      num_q <= '0;
      lvl_q <= '0;
      sw_q  <= 1'b0;
    end else if (accept_i) begin
      tmp_q <= flg_i;
      sw_q  <= !hw_sel_i;
      if (!hw_sel_i) begin
        num_q <= sw_num_i;
        lvl_q <= flg_i[IPL_LSB +: LVL_W];
      end
    end else if (st_i == ST_INFO && queue_ok_i) begin
      num_q <= rdata_i[NUM_W-1:0];
      lvl_q <= rdata_i[INFO_LVL_LSB +: LVL_W];
    end
  end

  // upper half of the software number range keeps the stack select
  assign keep_u = sw_q && num_q[NUM_W-1];

  always_comb begin
    flg_save = tmp_q;
    flg_save[FLG_IEN] = 1'b0;
    flg_save[FLG_DBG] = 1'b0;
    if (!keep_u) flg_save[FLG_USP] = 1'b0;
    flg_ipl = flg_save;
    flg_ipl[IPL_LSB +: LVL_W] = lvl_q;
  end

  assign flg_o    = (st_i == ST_IPL) ? flg_ipl : flg_save;
  assign flg_we_o = (st_i == ST_SAVE) || (st_i == ST_IPL);
  assign tmp_o    = tmp_q;
  assign num_o    = num_q;
  assign u_sel_o  = flg_save[FLG_USP];

  assert_save_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SAVE) |-> (flg_we_o && !flg_o[FLG_IEN] && !flg_o[FLG_DBG]));
  assert_hw_selects_isp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SAVE && !sw_q) |-> !u_sel_o);
  assert_sw_keeps_u_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SAVE && sw_q && num_q[NUM_W-1]) |-> (u_sel_o == tmp_q[FLG_USP]));
  assert_level_loaded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IPL) |-> (flg_we_o && flg_o[IPL_LSB +: LVL_W] == lvl_q));
endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
  import irq_entry_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FIX_BASE = 20'hFFF00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               st_i,
  input  logic              accept_i,
  input  logic              queue_ok_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] isp_i,
  input  logic [ADDR_W-1:0] usp_i,
  input  logic [ADDR_W-1:0] vbase_i,
  input  logic [FLG_W-1:0]  tmp_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic              u_sel_i,
  input  logic [RD_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              irq_ack_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              sp_we_o,
  output logic              sp_u_o,
  output logic              done_o
);
  localparam int VEC_BYTES = 3;
  localparam int PAD_W     = ADDR_W - NUM_W - 2;

  logic [ADDR_W-1:0] pc_q, sp_q, vec_base, vec_addr;
  logic [BYTE_W-1:0] vb_q [VEC_BYTES];
  logic              unused_bus;

  assign unused_bus = ^{rdata_i[RD_W-1:BYTE_W], tmp_i[IPL_LSB-1:BYTE_W]};

  assign vec_base = num_i[NUM_W-1] ? vbase_i : FIX_BASE;
  assign vec_addr = vec_base + {{PAD_W{1'b0}}, num_i, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      sp_q <= '0;
    end else begin
      if (accept_i)         pc_q <= pc_i;
      if (st_i == ST_SAVE)  sp_q <= u_sel_i ? usp_i : isp_i;
    end
  end

  for (genvar k = 0; k < VEC_BYTES; k++) begin : g_vec
    st_e slot;
    assign slot = st_e'(ST_VEC0 + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           vb_q[k] <= '0;
      else if (st_i == slot) vb_q[k] <= rdata_i[BYTE_W-1:0];
    end
  end

  always_comb begin
    addr_o    = '0;
    rd_o      = 1'b0;
    wr_o      = 1'b0;
    wdata_o   = '0;
    irq_ack_o = 1'b0;
    done_o    = 1'b0;
    unique case (st_i)
      ST_INFO: begin
        rd_o      = queue_ok_i;
        irq_ack_o = queue_ok_i;
      end
      ST_PUSH0: begin
        wr_o = 1'b1; addr_o = sp_q - ADDR_W'(2); wdata_o = tmp_i[BYTE_W-1:0];
      end
      ST_PUSH1: begin
        wr_o = 1'b1; addr_o = sp_q - ADDR_W'(1);
        wdata_o = {tmp_i[FLG_W-1:IPL_LSB], pc_q[ADDR_W-1:16]};
      end
      ST_PUSH2: begin
        wr_o = 1'b1; addr_o = sp_q - ADDR_W'(4); wdata_o = pc_q[7:0];
      end
      ST_PUSH3: begin
        wr_o = 1'b1; addr_o = sp_q - ADDR_W'(3); wdata_o = pc_q[15:8];
      end
      ST_VEC0: begin rd_o = 1'b1; addr_o = vec_addr; end
      ST_VEC1: begin rd_o = 1'b1; addr_o = vec_addr + ADDR_W'(1); end
      ST_VEC2: begin rd_o = 1'b1; addr_o = vec_addr + ADDR_W'(2); end
      ST_LOAD: done_o = 1'b1;
      default: ;
    endcase
  end

  assign pc_o    = {vb_q[2][ADDR_W-17:0], vb_q[1], vb_q[0]};
  assign pc_we_o = done_o;
  assign sp_o    = sp_q - ADDR_W'(4);
  assign sp_we_o = done_o;
  assign sp_u_o  = u_sel_i;

  assert_one_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  assert_wait_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_INFO && !queue_ok_i) |-> (!rd_o && !irq_ack_o));
  assert_push_follows_save_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PUSH0) |-> (wr_o && $past(st_i == ST_SAVE)));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_vec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pc_we_o && sp_we_o && $past(st_i == ST_VEC2)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_done_i,
  input  logic              str_susp_i,
  input  logic              irq_pend_i,
  input  logic              sw_req_i,
  input  logic [NUM_W-1:0]  sw_num_i,
  input  logic              queue_ok_i,
  input  logic [FLG_W-1:0]  flg_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] isp_i,
  input  logic [ADDR_W-1:0] usp_i,
  input  logic [ADDR_W-1:0] vbase_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wdata_o,
  input  logic [RD_W-1:0]   rdata_i,
  output logic              irq_ack_o,
  output logic [FLG_W-1:0]  flg_o,
  output logic              flg_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              sp_we_o,
  output logic              sp_u_o,
  output logic              done_o
);
  st_e              st;
  logic             accept, hw_sel, u_sel;
  logic [FLG_W-1:0] tmp_flg;
  logic [NUM_W-1:0] num;

  irq_entry_fsm u_fsm (
    .clk_i, .rst_ni, .insn_done_i, .str_susp_i, .irq_pend_i, .sw_req_i, .queue_ok_i,
    .st_o(st), .accept_o(accept), .hw_sel_o(hw_sel)
  );

  irq_entry_flags u_flags (
    .clk_i, .rst_ni, .st_i(st), .accept_i(accept), .hw_sel_i(hw_sel),
    .queue_ok_i, .sw_num_i, .flg_i, .rdata_i,
    .flg_o, .flg_we_o, .tmp_o(tmp_flg), .num_o(num), .u_sel_o(u_sel)
  );

  irq_entry_bus u_bus (
    .clk_i, .rst_ni, .st_i(st), .accept_i(accept), .queue_ok_i,
    .pc_i, .isp_i, .usp_i, .vbase_i, .tmp_i(tmp_flg), .num_i(num), .u_sel_i(u_sel),
    .rdata_i, .addr_o, .rd_o, .wr_o, .wdata_o, .irq_ack_o,
    .pc_o, .pc_we_o, .sp_o, .sp_we_o, .sp_u_o, .done_o
  );
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        insn_done_i = 0, str_susp_i = 0, irq_pend_i = 0, sw_req_i = 0, queue_ok_i = 0;
  logic [5:0]  sw_num_i = '0;
  logic [15:0] flg_i = '0, rdata_i, info_word = '0;
  logic [19:0] pc_i = '0, isp_i = '0, usp_i = '0, vbase_i = '0;
  logic [19:0] addr_o, pc_o, sp_o;
  logic        rd_o, wr_o, irq_ack_o, flg_we_o, pc_we_o, sp_we_o, sp_u_o, done_o;
  logic [7:0]  wdata_o;
  logic [15:0] flg_o;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_entry_seq u0 (.*);

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction

  always_comb rdata_i = (addr_o == 20'd0) ? info_word : {8'h00, mb(addr_o)};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input bit hw, input bit susp, input bit both, input logic [5:0] num,
                     input logic [2:0] lvl, input int qwait, input logic [15:0] flg,
                     input logic [19:0] pc, input logic [19:0] isp, input logic [19:0] usp,
                     input logic [19:0] vb);
    logic [15:0] sv, ip;
    logic [19:0] sp, vec, npc;
    logic [7:0]  b0, b1, b2;
    bit keep;
    int w;
    info_word = {5'd0, lvl, 2'd0, num};
    flg_i = flg; pc_i = pc; isp_i = isp; usp_i = usp; vbase_i = vb;
    queue_ok_i = (qwait == 0);
    irq_pend_i = hw; insn_done_i = !(hw && susp); str_susp_i = hw && susp;
    sw_req_i = !hw || both; sw_num_i = hw ? ~num : num;
    @(negedge clk_i);
    irq_pend_i = 0; insn_done_i = 0; str_susp_i = 0; sw_req_i = 0;
    keep = !hw && (num >= 6'd32);
    sv = flg & ~16'h0042;
    if (!keep) sv[7] = 1'b0;
    ip = sv; ip[14:12] = hw ? lvl : flg[14:12];
    sp = sv[7] ? usp : isp;
    vec = ((num < 6'd32) ? 20'hFFF00 : vb) + {12'd0, num, 2'b00};
    b0 = mb(vec); b1 = mb(vec + 20'd1); b2 = mb(vec + 20'd2);
    npc = {b2[3:0], b1, b0};
    if (hw) begin
      w = 0;
      while (1) begin
        queue_ok_i = (w >= qwait);
        #1;
        if (!queue_ok_i) begin
          chk("R4 rd in wait", rd_o, 0);
          chk("R4 ack in wait", irq_ack_o, 0);
          w++;
          @(negedge clk_i);
        end else begin
          chk(susp ? "R2 info rd" : "R1 R3 info rd", rd_o, 1);
          chk("R3 info ack", irq_ack_o, 1);
          chk("R3 info addr", addr_o, 0);
          break;
        end
      end
      @(negedge clk_i);
    end
    chk(hw ? "R5 flg_we" : "R6 flg_we", flg_we_o, 1);
    chk(hw ? "R5 flags" : "R6 flags", flg_o, sv);
    chk("R6 no rd at save", rd_o, 0);
    @(negedge clk_i);
    chk("R7 w0", {wr_o, addr_o, wdata_o}, {1'b1, sp - 20'd2, flg[7:0]});
    @(negedge clk_i);
    chk("R7 w1", {wr_o, addr_o, wdata_o}, {1'b1, sp - 20'd1, flg[15:12], pc[19:16]});
    @(negedge clk_i);
    chk("R7 w2", {wr_o, addr_o, wdata_o}, {1'b1, sp - 20'd4, pc[7:0]});
    @(negedge clk_i);
    chk("R7 w3", {wr_o, addr_o, wdata_o}, {1'b1, sp - 20'd3, pc[15:8]});
    @(negedge clk_i);
    chk("R8 flg_we", flg_we_o, 1);
    chk("R8 level", flg_o, ip);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R9 vec read", {rd_o, wr_o, addr_o}, {2'b10, vec + 20'(k)});
    end
    @(negedge clk_i);
    chk("R10 done", {done_o, pc_we_o, sp_we_o}, 3'b111);
    chk("R9 R10 pc", pc_o, npc);
    chk("R10 sp", sp_o, sp - 20'd4);
    chk("R10 sp select", sp_u_o, sv[7]);
    @(negedge clk_i);
    chk("R10 single pulse", {done_o, rd_o, wr_o, flg_we_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("reset strobes", {rd_o, wr_o, irq_ack_o, done_o, flg_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: pending without a boundary, and sw without retire, do nothing
    irq_pend_i = 1; sw_req_i = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R1 ignored", {rd_o, wr_o, irq_ack_o, flg_we_o}, 0);
    end
    irq_pend_i = 0; sw_req_i = 0;
    @(negedge clk_i);
    for (int n = 0; n < 64; n++)
      run(1, n[0], 0, 6'(n), 3'(n), n % 3, 16'h5A5A ^ 16'(n * 291),
          20'h12345 + 20'(n * 273), 20'h00800 + 20'(n), 20'h0F000 + 20'(n * 2),
          20'h0C000 + 20'(n * 16));
    for (int n = 0; n < 64; n++)
      run(0, 0, 0, 6'(n), 3'd0, 0, (16'(n * 2439) & 16'hFF7F) | (n[1] ? 16'h0080 : 16'h0),
          20'h54321 - 20'(n * 7), 20'h00400 + 20'(n * 4), 20'h0E000 + 20'(n * 8),
          20'hA0000 + 20'(n * 16));
    // R11: both qualify, hardware wins
    for (int n = 0; n < 4; n++)
      run(1, 0, 1, 6'(n * 17 + 3), 3'(7 - n), 1, 16'h00C0 | 16'(n << 12),
          20'h0ABCD, 20'h00900, 20'h0D000, 20'h0B000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule